// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the address sequence for a four-beat burst into a synchronous burst memory. When the controller raises either of its two burst-start inputs, the full external address is captured and becomes beat zero. From then on, each cycle with the step input high moves to the next beat, and each cycle with step low repeats the current beat. Only the two lowest address bits change during a burst. The upper bits keep the value they were loaded with.

The two low bits follow one of two orders, chosen by a static order input. In interleaved order, the low bits are the captured start bits XOR the beat count. This is the ordering that processor cache-line fills expect. In linear order, the low bits are the start bits plus the beat count, modulo four. The order input is registered on every clock, and reset sets that register to interleaved. A board that ties the input high therefore gets the same order that reset provides.

The controller upstream resolves strobe priority and chip-enable qualification. The sequencer only sees the result. It does not access memory or handle data.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `beat` = 0, `cur_addr` = 0 and the registered order set to interleaved.
- R2: A clock edge with `load_a` or `load_b` high captures `ext_addr`. After that edge, `beat` is 0 and `cur_addr` equals the captured address, in either order.
- R3: Between loads, `cur_addr[15:2]` does not change, whatever `step` and `order_ilv` do.
- R4: With no load, an edge with `step` high increases `beat` by one modulo 4. A step from beat 3 returns the low bits to their start value.
- R5: With no load, an edge with `step` low leaves `beat` and `cur_addr` unchanged, as long as the registered order does not change.
- R6: In interleaved order, `cur_addr[1:0]` equals start XOR `beat`. For example, start 01 gives 01, 00, 11, 10, and start 11 gives 11, 10, 01, 00.
- R7: In linear order, `cur_addr[1:0]` equals (start + `beat`) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R8: `order_ilv` is sampled on every edge, with 1 = interleaved and 0 = linear. The outputs follow the value sampled at the most recent edge, and a change in the middle of a burst takes effect at the next edge.
- R9: When a load and a step occur on the same edge, the load wins. `beat` becomes 0 and the new address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_a | input | 1 | Burst start from the processor-side strobe, active high |
| load_b | input | 1 | Burst start from the controller-side strobe, active high |
| step | input | 1 | Advance to next beat when high; hold when low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| ext_addr | input | 16 | External start address |
| cur_addr | output | 16 | Address of the current beat |
| beat | output | 2 | Index of the current beat |

## Verification
Two functions can fall in the same cycle: starting a new burst and advancing the current one. Also, a change of order can arrive in the middle of a burst. The bench raises a strobe together with `step` while the old burst sits at a non-zero beat. It expects beat 0 and the new address on the next cycle, not an advanced beat. It also flips `order_ilv` while a burst is suspended. It expects the low bits of that same beat to be re-mapped under the new order on the following cycle. A behavioural model, built from integers, is compared with both outputs on every clock.

// File: rtl/bs_pkg.sv
// Shared definitions for the burst address sequencer.
// Assumes: the order encoding matches the order_ilv pin (1 = interleaved).
package bs_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/bs_addr_latch.sv
// Holds the upper address bits and the low start bits of the current burst.
// Assumes: load is already the OR of both strobes; reset is synchronous.
module bs_addr_latch #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2,
    localparam int UPPER_W = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [UPPER_W-1:0] upper_q,
    output logic [BEAT_W-1:0] start_q
);
    // Capture the external address when a burst begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (load) begin
            upper_q <= ext_addr[ADDR_W-1:BEAT_W];
            start_q <= ext_addr[BEAT_W-1:0];
        end
    end
endmodule

// File: rtl/bs_beat_ctr.sv
// Beat counter: it clears on load and wraps naturally at 2**BEAT_W.
// Assumes: load has priority over step.
module bs_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat_q
);
    // Clear on reset or load, advance on step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/bs_low_map.sv
// Maps the start bits and the beat count to the low address bits.
// Assumes: purely combinational; the order input is already registered.
module bs_low_map #(
    parameter int BEAT_W = 2
) (
    input  bs_pkg::order_e    order,
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] ilv_bits;
    logic [BEAT_W-1:0] lin_bits;

    // Interleaved: one XOR per bit, built by the generate loop.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
        assign ilv_bits[i] = start[i] ^ beat[i];
    end

    // Linear: modular add, where truncation gives the wrap.
    assign lin_bits = start + beat;

    // Select the order that the registered mode asks for.
    always_comb begin
        if (order == bs_pkg::ORD_INTERLEAVE) low = ilv_bits;
        else                                 low = lin_bits;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Top level of the burst address sequencer.
// Assumes: the controller has already qualified the strobes with the chip
// enables; order_ilv is quasi-static and is registered here.
module burst_addr_seq #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_a,
    input  logic              load_b,
    input  logic              step,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BEAT_W-1:0] beat
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic              load;
    logic [UPPER_W-1:0] upper_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] low;
    bs_pkg::order_e    order_q;

    // Either strobe starts a burst.
    assign load = load_a | load_b;

    // Sample the order pin each cycle; reset selects interleaved.
    always_ff @(posedge clk) begin
        if (!rst_n) order_q <= bs_pkg::ORD_INTERLEAVE;
        else        order_q <= bs_pkg::order_e'(order_ilv);
    end

    bs_addr_latch #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ext_addr (ext_addr),
        .upper_q  (upper_q),
        .start_q  (start_q)
    );

    bs_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .beat_q (beat)
    );

    bs_low_map #(.BEAT_W(BEAT_W)) u_map (
        .order (order_q),
        .start (start_q),
        .beat  (beat),
        .low   (low)
    );

    // Assemble the output address.
    assign cur_addr = {upper_q, low};
endmodule

// File: rtl/bs_checker.sv
// Port-level properties of the sequencer, bound to the top module.
module bs_checker #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_a,
    input logic              load_b,
    input logic              step,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [BEAT_W-1:0] beat
);
    logic ld;
    assign ld = load_a | load_b;

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (beat == '0) && (cur_addr == $past(ext_addr)));

    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));

    p_step_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && step) |=> beat == BEAT_W'($past(beat) + 1'b1));

    p_hold_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !step) |=> $stable(beat));

    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && step) |=> beat == '0);
endmodule

bind burst_addr_seq bs_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_a   (load_a),
    .load_b   (load_b),
    .step     (step),
    .ext_addr (ext_addr),
    .cur_addr (cur_addr),
    .beat     (beat)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_a = 1'b0, load_b = 1'b0, step = 1'b0, order_ilv = 1'b1;
    logic [15:0] ext_addr = '0;
    logic [15:0] cur_addr;
    logic [1:0]  beat;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Behavioural reference state
    int m_base = 0, m_cnt = 0, m_ilv = 1;

    always #10 clk = ~clk;

    burst_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b),
        .step(step), .order_ilv(order_ilv), .ext_addr(ext_addr),
        .cur_addr(cur_addr), .beat(beat)
    );

    function automatic int exp_addr();
        int s, lo;
        s  = m_base % 4;
        lo = m_ilv ? (s ^ m_cnt) : ((s + m_cnt) % 4);
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic compare(string tag);
        n_chk++;
        if (int'(cur_addr) != exp_addr() || int'(beat) != m_cnt) begin
            n_fail++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, cur_addr, beat, exp_addr(), m_cnt);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the edge, compare at the next falling edge
    task automatic cyc(input bit la, input bit lb, input bit st, input bit md,
                       input logic [15:0] a, input string tag);
        load_a = la; load_b = lb; step = st; order_ilv = md; ext_addr = a;
        @(posedge clk);
        if (!rst_n) begin
            m_base = 0; m_cnt = 0; m_ilv = 1;
        end else begin
            if (la || lb) begin m_base = int'(a); m_cnt = 0; end
            else if (st)  m_cnt = (m_cnt + 1) % 4;
            m_ilv = md;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        @(negedge clk);
        cyc(0, 0, 1, 0, 16'hFFFF, "R1 reset");
        cyc(1, 0, 1, 1, 16'h1234, "R1 reset");
        rst_n = 1'b1;
        cyc(0, 0, 0, 1, 16'h0, "R1 idle after reset");

        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                string t;
                t = (md != 0) ? "R6" : "R7";
                a = 16'(16'hA5F0 + 16'(s) + 16'(md * 16'h0100));
                if (s % 2 == 0) cyc(1, 0, 0, md[0], a, "R2 load_a");
                else            cyc(0, 1, 0, md[0], a, "R2 load_b");
                cyc(0, 0, 1, md[0], 16'h0, t);
                cyc(0, 0, 0, md[0], 16'hFFFF, "R5 suspend");
                cyc(0, 0, 0, md[0], 16'h0, "R5 suspend");
                cyc(0, 0, 1, md[0], 16'h0, t);
                cyc(0, 0, 1, md[0], 16'h0, t);
                cyc(0, 0, 1, md[0], 16'h0, "R4 wrap");
                cyc(0, 0, 1, md[0], 16'h0, "R3 upper");
            end
        end

        // R9: load and step on the same edge, mid-burst
        cyc(1, 0, 0, 1, 16'h7772, "R2");
        cyc(0, 0, 1, 1, 16'h0, "R6");
        cyc(0, 0, 1, 1, 16'h0, "R6");
        cyc(0, 1, 1, 1, 16'h0C01, "R9 load beats step");
        cyc(1, 1, 1, 0, 16'h3333, "R9 both strobes and step");

        // R8: order flips while suspended mid-burst
        cyc(0, 0, 1, 0, 16'h0, "R7");
        cyc(0, 0, 0, 1, 16'h0, "R8 switch to interleaved");
        cyc(0, 0, 0, 0, 16'h0, "R8 switch to linear");
        cyc(0, 0, 1, 1, 16'h0, "R8 step after switch");

        // R1: reset mid-burst
        rst_n = 1'b0;
        cyc(0, 0, 1, 0, 16'h0, "R1 reset mid-burst");
        rst_n = 1'b1;
        cyc(0, 0, 1, 1, 16'h0, "R1 first step after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule